// File: doc/BRIEF.md
# Stochastic Pulse-Stream Neuron

This block is a single digital neuron whose arithmetic runs on random pulse trains instead of binary words. A value is carried by how often a line is high. Each synapse turns its 8-bit weight into a pulse train, using a pseudo-random generator of its own so that the synapses stay decorrelated. It multiplies the incoming activation train by that weight train with one AND gate. The product trains of all synapses are joined by an OR, which acts as the adder.

The merged train feeds a programmable divide-by-N prescaler. Each prescaler tick steps a saturating integrator up by one. An output generator compares a pseudo-random byte against the integrator level on every cycle, which turns the level back into an output pulse train.

A host first writes the weights, the divisor and a common seed through a small write port. It then strobes `start`. The neuron evaluates over a fixed window of 256 cycles and raises `done` when the window ends. A longer window gives finer precision at the cost of more cycles.

Top module: `stoch_neuron`

## Requirements
- R1: While reset is held low and on the first cycle after it, `busy`, `done` and `out_pulse` are 0 and `level` is 0. Reset also sets the weights to 0, the divisor to 1 and the seed to 1.
- R2: A synapse whose weight is 0 never contributes, even if its input is held high.
- R3: A synapse whose input is held low never contributes, whatever its weight.
- R4: When `start` is seen high on a clock edge, `busy` stays high for exactly 256 evaluation edges and then drops.
  - `done` goes high on that same edge and stays high until the next `start`.
  - `level` does not change while the block is idle.
- R5: The integrator steps once for every N merged pulses, where N is the divisor. A divisor of 0 acts as 256. With the same streams, the level for N=4 equals the level for N=1 divided by 4, rounded down.
- R6: Each synapse pulse generator is reloaded from the seed at `start`. The same seed, weights and inputs therefore always give the same final `level`.
- R7: A synapse product is high only when its input is high and its weight train fires. The weight train fires when the low 8 bits of that synapse's generator are below the weight. With weight 255 and a steady high input, 240 to 256 increments result at N=1.
- R8: The products are merged by OR. The level with two synapses active is at least the larger single-synapse level and at most the sum of the two.
- R9: The integrator saturates at its all-ones value instead of wrapping. A 4-bit integrator driven by a dense stream ends the window at exactly 15.
- R10: `out_pulse` is a registered pulse that fires when an 8-bit pseudo-random value is below `level`. At level 0 it never fires. At a level of 240 or more it fires on at least 200 of 256 cycles.
- R11: A `start` during a window restarts it. A fresh 256-edge window follows with state reloaded, so the result equals that of an undisturbed run.
- R12: The write port uses these addresses, each write taking effect on the next cycle:
  - addresses 0 to 3 hold the weights, taken from data bits 7:0;
  - address 4 holds the divisor, taken from bits 7:0;
  - address 5 holds the seed, taken from bits 15:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Starts a new evaluation window and clears the integrator |
| in_pulse | input | 4 | Activation pulse train of each synapse |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | 16 | Configuration write data |
| out_pulse | output | 1 | Output pulse train |
| busy | output | 1 | Evaluation window in progress |
| done | output | 1 | Window finished; level is final |
| level | output | 16 | Integrator value |

## Verification
The start strobe is captured at edge E0, and the window then runs over edges E1 to E256. The bench therefore samples `busy`=1 and `done`=0 after E255, and `done`=1 with the final `level` after E256. Each read happens on the falling edge after the clock edge under test. A configuration write is applied a full cycle before any `start`. Output pulse density is counted only once `done` is high, which keeps `level` stable while it is counted. The expected results come from comparing whole runs with one another, using the same seed and varying one factor: the divisor, the active synapses, or a restart. This makes them exact without modelling the pseudo-random generators.

// File: rtl/sn_pkg.sv
// Shared helpers for the stochastic neuron: generator step and seed derivation.
// Assumes a 16-bit maximal-length shift-register generator.
package sn_pkg;
    localparam int GEN_W = 16;

    // Advance the generator by one state (taps 16,15,13,4).
    function automatic logic [GEN_W-1:0] gen_step(input logic [GEN_W-1:0] s);
        return {s[GEN_W-2:0], s[15] ^ s[14] ^ s[12] ^ s[3]};
    endfunction

    // Derive a non-zero per-generator start state from the common seed.
    function automatic logic [GEN_W-1:0] seed_for(input logic [GEN_W-1:0] base,
                                                  input int unsigned idx);
        logic [GEN_W-1:0] m;
        m = base ^ (GEN_W'(idx + 1) * 16'h9E37);
        if (m == '0) m = 16'h0001;
        return m;
    endfunction
endpackage

// File: rtl/sn_synapse.sv
// One synapse: a private generator turns the weight into a pulse train, and an
// AND gate multiplies it with the input train. Assumes WGT_W <= 16.
module sn_synapse #(
    parameter int WGT_W = 8,
    parameter int IDX   = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [15:0]      seed,
    input  logic [WGT_W-1:0] weight,
    input  logic             in_pulse,
    output logic             prod
);
    import sn_pkg::*;

    logic [GEN_W-1:0] gen_q;

    // Generator state: reloaded at window start, otherwise free running.
    always_ff @(posedge clk) begin
        if (!rst_n)     gen_q <= seed_for(16'h0001, IDX);
        else if (load)  gen_q <= seed_for(seed, IDX);
        else            gen_q <= gen_step(gen_q);
    end

    assign prod = in_pulse && (gen_q[WGT_W-1:0] < weight);
endmodule

// File: rtl/sn_prescaler.sv
// Divide-by-N prescaler: emits one tick per N merged pulses while enabled.
// A divisor of 0 behaves as 2**PRE_W.
module sn_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             en,
    input  logic             din,
    input  logic [PRE_W-1:0] div,
    output logic             tick
);
    logic [PRE_W-1:0] cnt_q;
    logic             last;

    assign last = (cnt_q == div - 1'b1);
    assign tick = en && din && last;

    // Pulse counter: restarts at window start and after each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt_q <= '0;
        else if (en && din)  cnt_q <= last ? '0 : cnt_q + 1'b1;
    end
endmodule

// File: rtl/sn_integrator.sv
// Saturating up-counter that accumulates prescaler ticks.
module sn_integrator #(
    parameter int INT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             inc,
    output logic [INT_W-1:0] level
);
    // Accumulate ticks, holding at all-ones instead of wrapping.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)       level <= '0;
        else if (inc && ~&level)   level <= level + 1'b1;
    end
endmodule

// File: rtl/sn_pulse_gen.sv
// Output generator: a registered pulse fires when a CMP_W-bit random value is
// below the integrator level, so density tracks level / 2**CMP_W.
module sn_pulse_gen #(
    parameter int INT_W = 16,
    parameter int CMP_W = 8,
    parameter int IDX   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [15:0]      seed,
    input  logic [INT_W-1:0] level,
    output logic             out_pulse
);
    import sn_pkg::*;

    localparam int W = (INT_W > CMP_W) ? INT_W : CMP_W;

    logic [GEN_W-1:0] gen_q;

    // Generator state: reloaded at window start, otherwise free running.
    always_ff @(posedge clk) begin
        if (!rst_n)     gen_q <= seed_for(16'h0001, IDX);
        else if (load)  gen_q <= seed_for(seed, IDX);
        else            gen_q <= gen_step(gen_q);
    end

    // Compare the random slice with the level and register the result.
    always_ff @(posedge clk) begin
        if (!rst_n) out_pulse <= 1'b0;
        else        out_pulse <= W'(gen_q[CMP_W-1:0]) < W'(level);
    end
endmodule

// File: rtl/stoch_neuron.sv
// Stochastic pulse-stream neuron top: configuration registers, window control,
// N_SYN synapses merged by OR, prescaler, integrator and output generator.
// Assumes start is a single-cycle strobe; configuration is written before start.
module stoch_neuron #(
    parameter int N_SYN   = 4,
    parameter int WGT_W   = 8,
    parameter int PRE_W   = 8,
    parameter int INT_W   = 16,
    parameter int WIN_LEN = 256,
    parameter int ADDR_W  = $clog2(N_SYN + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [N_SYN-1:0]  in_pulse,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [15:0]       cfg_wdata,
    output logic              out_pulse,
    output logic              busy,
    output logic              done,
    output logic [INT_W-1:0]  level
);
    localparam int CNT_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;

    logic [WGT_W-1:0] weight_q [N_SYN];
    logic [PRE_W-1:0] div_q;
    logic [15:0]      seed_q;
    logic [CNT_W-1:0] win_cnt_q;
    logic [N_SYN-1:0] prod;
    logic             merged;
    logic             tick;

    // Configuration registers written through the host port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_SYN; i++) weight_q[i] <= '0;
            div_q  <= PRE_W'(1);
            seed_q <= 16'h0001;
        end else if (cfg_we) begin
            for (int i = 0; i < N_SYN; i++)
                if (cfg_addr == ADDR_W'(i)) weight_q[i] <= cfg_wdata[WGT_W-1:0];
            if (cfg_addr == ADDR_W'(N_SYN))     div_q  <= cfg_wdata[PRE_W-1:0];
            if (cfg_addr == ADDR_W'(N_SYN + 1)) seed_q <= cfg_wdata;
        end
    end

    // Window control: start opens a WIN_LEN-edge window, done marks its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            done      <= 1'b0;
            win_cnt_q <= '0;
        end else if (start) begin
            busy      <= 1'b1;
            done      <= 1'b0;
            win_cnt_q <= '0;
        end else if (busy) begin
            if (win_cnt_q == CNT_W'(WIN_LEN - 1)) begin
                busy <= 1'b0;
                done <= 1'b1;
            end else begin
                win_cnt_q <= win_cnt_q + 1'b1;
            end
        end
    end

    for (genvar g = 0; g < N_SYN; g++) begin : g_syn
        sn_synapse #(.WGT_W(WGT_W), .IDX(g)) u_syn (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (start),
            .seed     (seed_q),
            .weight   (weight_q[g]),
            .in_pulse (in_pulse[g]),
            .prod     (prod[g])
        );
    end

    assign merged = |prod;

    sn_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (start),
        .en    (busy),
        .din   (merged),
        .div   (div_q),
        .tick  (tick)
    );

    sn_integrator #(.INT_W(INT_W)) u_int (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (start),
        .inc   (tick),
        .level (level)
    );

    sn_pulse_gen #(.INT_W(INT_W), .CMP_W(WGT_W), .IDX(N_SYN)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start),
        .seed      (seed_q),
        .level     (level),
        .out_pulse (out_pulse)
    );
endmodule

// File: rtl/sn_checker.sv
// Temporal checks on the neuron's window control and integrator behaviour.
module sn_checker #(
    parameter int INT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             merged,
    input logic             tick,
    input logic [INT_W-1:0] level
);
    // R4: busy and done are never high together.
    p_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R4: done only rises at the end of a busy window.
    p_done_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

    // R4: level is held while idle.
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(level));

    // R11: start clears the integrator and opens a window.
    p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (level == '0 && busy));

    // R9: the integrator steps by at most one and never wraps.
    p_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start) |=> (level == $past(level) || level == $past(level) + 1'b1));

    // R5: a prescaler tick needs a merged pulse inside a window.
    p_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (merged && busy));
endmodule

bind stoch_neuron sn_checker #(.INT_W(INT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .merged (merged),
    .tick   (tick),
    .level  (level)
);

// File: tb/tb_stoch_neuron.sv
// Scoreboard bench: driver steps push expected ranges, a monitor task pops
// them and compares with what the design produced.
module tb_stoch_neuron;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  in_pulse = '0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        out_pulse, busy, done;
    logic [15:0] level;
    logic        out_s, busy_s, done_s;
    logic [3:0]  level_s;

    typedef struct { string tag; int lo; int hi; } exp_t;
    exp_t exp_q[$];
    int n_chk = 0, n_bad = 0;
    int lvl, lvl_s;
    bit finished = 0;

    always #5 clk = ~clk;

    stoch_neuron dut (.clk(clk), .rst_n(rst_n), .start(start), .in_pulse(in_pulse),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .out_pulse(out_pulse), .busy(busy), .done(done), .level(level));

    stoch_neuron #(.INT_W(4)) dut_small (.clk(clk), .rst_n(rst_n), .start(start),
        .in_pulse(in_pulse), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .out_pulse(out_s), .busy(busy_s), .done(done_s), .level(level_s));

    // Driver side: queue an expected inclusive range.
    task automatic push(input string tag, input int lo, input int hi);
        exp_t e;
        e.tag = tag; e.lo = lo; e.hi = hi;
        exp_q.push_back(e);
    endtask

    // Monitor side: pop the oldest expectation and compare.
    task automatic observe(input int act);
        exp_t e;
        e = exp_q.pop_front();
        n_chk++;
        if (act < e.lo || act > e.hi) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d..%0d", e.tag, act, e.lo, e.hi);
        end
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'(addr); cfg_wdata = 16'(data);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_w(input int w0, input int w1, input int w2, input int w3);
        wr(0, w0); wr(1, w1); wr(2, w2); wr(3, w3);
    endtask

    // One full window; done timing checked against E255/E256.
    task automatic run_window();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (255) @(negedge clk);
        push("R4 busy after E255", 1, 1);  observe(busy);
        push("R4 done after E255", 0, 0);  observe(done);
        @(negedge clk);
        push("R4 done after E256", 1, 1);  observe(done);
        push("R4 busy after E256", 0, 0);  observe(busy);
        lvl = level; lvl_s = level_s;
    endtask

    task automatic count_out(input int n, output int c);
        c = 0;
        repeat (n) begin @(negedge clk); c += out_pulse; end
    endtask

    initial begin
        int l1, a, b, c, cnt, held;
        repeat (3) @(negedge clk);
        push("R1 busy", 0, 0);   observe(busy);
        push("R1 done", 0, 0);   observe(done);
        push("R1 level", 0, 0);  observe(level);
        push("R1 out", 0, 0);    observe(out_pulse);
        rst_n = 1'b1;
        @(negedge clk);
        push("R1 level after release", 0, 0); observe(level);
        push("R1 busy after release", 0, 0);  observe(busy);

        // R2: zero weights, inputs high.
        in_pulse = 4'hF;
        run_window();
        push("R2 zero weight level", 0, 0); observe(lvl);
        count_out(64, cnt);
        push("R10 no pulses at level 0", 0, 0); observe(cnt);

        // R3: full weights, inputs low.
        set_w(255, 255, 255, 255);
        in_pulse = 4'h0;
        run_window();
        push("R3 low input level", 0, 0); observe(lvl);

        // R7/R9: single synapse, weight 255, N=1.
        set_w(255, 0, 0, 0);
        in_pulse = 4'b0001;
        run_window();
        l1 = lvl;
        push("R7 dense AND level", 240, 256); observe(l1);
        push("R9 small integrator saturates", 15, 15); observe(lvl_s);
        held = level;
        count_out(256, cnt);
        push("R4 level held while idle", held, held); observe(level);
        push("R10 dense output density", 200, 256); observe(cnt);

        // R6: identical rerun.
        run_window();
        push("R6 reproducible level", l1, l1); observe(lvl);

        // R5/R12: divisor 4, then divisor 0 (=256).
        wr(4, 4);
        run_window();
        push("R5 R12 divide by 4", l1 / 4, l1 / 4); observe(lvl);
        wr(4, 0);
        run_window();
        push("R5 divisor 0 acts as 256", l1 / 256, l1 / 256); observe(lvl);
        wr(4, 1);

        // R11: restart mid-window.
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (100) @(negedge clk);
        run_window();
        push("R11 restart equals clean run", l1, l1); observe(lvl);

        // R8: OR merge of two half-weight synapses, new seed.
        wr(5, 16'h5A3C);
        set_w(128, 128, 0, 0);
        in_pulse = 4'b0001; run_window(); a = lvl;
        in_pulse = 4'b0010; run_window(); b = lvl;
        in_pulse = 4'b0011; run_window(); c = lvl;
        push("R8 merged not below larger", (a > b) ? a : b, 1000); observe(c);
        push("R8 merged not above sum", 0, a + b); observe(c);
        push("R7 half weight nonzero", 1, 255); observe(a);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule